// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is a synchronous master that fetches one 16-bit conversion result from a three-wire serial converter. The converter has only a select, a clock and a data line. A start request drives the active-low select line low, which begins a conversion in the converter. The block then runs a serial clock derived from the system clock. The clock idles low and data is taken on its rising edges. Each transaction is 24 serial clocks long.

The converter sends eight leading zero bits and then the 16-bit result, most significant bit first. The block keeps the final 16 bits and raises the select line on the edge that ends the 24th clock. It then presents the result with a single-cycle valid strobe. A framing-error flag goes with the strobe when a leading bit was not zero.

Before the next transaction the select line stays high for a programmed number of cycles. A start that arrives during a transaction or during this gap is held and served once the gap has run out. An abort input ends a transaction at once, with no result.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, `cs_n_o` is 1 and `sclk_o`, `busy_o`, `valid_o` and `frame_err_o` are 0.
- R2: `sclk_o` is 0 whenever `cs_n_o` is 1. A completed transaction has exactly 24 rising edges of `sclk_o` while `cs_n_o` is 0.
- R3: While `cs_n_o` is 0, every high and every low phase of `sclk_o` lasts exactly HALF_DIV system-clock cycles. This includes the first low phase after the select line falls.
- R4: `data_o` carries captured serial bits 9 to 24 of the transaction. Bit 9 goes to `data_o[15]` and bit 24 to `data_o[0]`. Each bit is the value of `sdi_i` at a rising edge of `sclk_o`.
- R5: `cs_n_o` rises on the system-clock edge that ends the 24th high phase, with `sclk_o` returning to 0 on the same edge. `valid_o` is 1 for exactly that one cycle.
- R6: With CHECK_LEAD=1, `frame_err_o` is 1 together with `valid_o` when any of captured bits 1 to 8 was 1. It is 0 otherwise.
- R7: Between two transactions `cs_n_o` stays 1 for at least GAP_CYC system-clock cycles. This also holds after an abort.
- R8: A `start_i` pulse seen while `busy_o` is 1 is held pending and starts the next transaction after the gap. `busy_o` stays 1 from the first transaction through the second.
- R9: An `abort_i` pulse during a transaction sets `cs_n_o` to 1 and `sclk_o` to 0 on the next edge. No `valid_o` follows, and any pending start is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one transaction (single-cycle pulse) |
| abort_i | input | 1 | Cancel the transaction in progress |
| sdi_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low select to the converter |
| sclk_o | output | 1 | Serial clock, idles low |
| busy_o | output | 1 | Transaction or select-high gap in progress |
| data_o | output | 16 | Last conversion result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| frame_err_o | output | 1 | Leading bits were not all zero, qualified by `valid_o` |

## Verification
A wrong bit counter shows within one transaction as a wrong number of serial clocks. It also shows as a result shifted by one or more positions on `data_o`. A divider fault changes the measured phase widths from the first phase after the select line falls. A gap counter that ends early shortens the select-high time between back-to-back transactions. A pending flag that is lost or not cleared shows within a few hundred cycles, as either a missing second strobe or a transaction after an abort.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } rd_state_e;
endpackage

// File: rtl/adc_rd_tick.sv
// Half-period divider: pulses tick_o every HALF_DIV cycles while run_i is high.
module adc_rd_tick #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick_o = run_i && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run_i || tick_o) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  generate
    if (HALF_DIV > 1) begin : g_spacing
      // Two ticks never come back to back when the half period is longer than one cycle (R3).
      assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/adc_rd_shift.sv
// Serial capture register; the newest bit enters at position 0.
module adc_rd_shift #(
  parameter int FRAME_BITS = 24,
  parameter int DATA_BITS  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_i,
  input  logic                 cap_i,
  input  logic                 din_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 lead_nz_o
);
  localparam int LEAD_BITS = FRAME_BITS - DATA_BITS;

  logic [FRAME_BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clr_i) sh <= '0;
    else if (cap_i)   sh <= {sh[FRAME_BITS-2:0], din_i};
  end

  assign data_o    = sh[DATA_BITS-1:0];
  assign lead_nz_o = |sh[FRAME_BITS-1 -: LEAD_BITS];
endmodule

// File: rtl/adc_rd_gap.sv
// Select-high gap timer: done_o rises GAP_CYC cycles after load_i.
module adc_rd_gap #(
  parameter int GAP_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic done_o
);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load_i)      cnt <= GW'(GAP_CYC - 1);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done_o = (cnt == '0);
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int HALF_DIV   = 3,
  parameter int GAP_CYC    = 5,
  parameter int FRAME_BITS = 24,
  parameter int DATA_BITS  = 16,
  parameter bit CHECK_LEAD = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 abort_i,
  input  logic                 sdi_i,
  output logic                 cs_n_o,
  output logic                 sclk_o,
  output logic                 busy_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 frame_err_o
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam int HW    = $clog2(GAP_CYC + 1) + 1;

  rd_state_e              state;
  logic [CNT_W-1:0]       bit_cnt;
  logic                   pend;
  logic                   tick;
  logic                   gap_done;
  logic                   gap_load;
  logic                   launch;
  logic                   cap;
  logic [DATA_BITS-1:0]   sh_data;
  logic                   sh_lead_nz;

  adc_rd_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .run_i(state == ST_SHIFT && !abort_i), .tick_o(tick)
  );

  assign cap    = (state == ST_SHIFT) && !abort_i && tick && !sclk_o;
  assign launch = ((state == ST_IDLE) && (start_i || pend)) ||
                  ((state == ST_GAP) && gap_done && (start_i || pend));

  adc_rd_shift #(.FRAME_BITS(FRAME_BITS), .DATA_BITS(DATA_BITS)) u_shift (
    .clk(clk), .rst(rst), .clr_i(launch), .cap_i(cap), .din_i(sdi_i),
    .data_o(sh_data), .lead_nz_o(sh_lead_nz)
  );

  assign gap_load = (state == ST_SHIFT) &&
                    (abort_i || (tick && sclk_o && bit_cnt == CNT_W'(FRAME_BITS - 1)));

  adc_rd_gap #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst(rst), .load_i(gap_load), .done_o(gap_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cs_n_o      <= 1'b1;
      sclk_o      <= 1'b0;
      busy_o      <= 1'b0;
      bit_cnt     <= '0;
      pend        <= 1'b0;
      data_o      <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      if (start_i && state != ST_IDLE) pend <= 1'b1;
      if (launch) begin
        state   <= ST_SHIFT;
        cs_n_o  <= 1'b0;
        sclk_o  <= 1'b0;
        busy_o  <= 1'b1;
        bit_cnt <= '0;
        pend    <= 1'b0;
      end else begin
        unique case (state)
          ST_SHIFT: begin
            if (abort_i) begin
              state  <= ST_GAP;
              cs_n_o <= 1'b1;
              sclk_o <= 1'b0;
              pend   <= 1'b0;
            end else if (tick) begin
              sclk_o <= ~sclk_o;
              if (sclk_o) begin
                if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
                  state       <= ST_GAP;
                  cs_n_o      <= 1'b1;
                  valid_o     <= 1'b1;
                  data_o      <= sh_data;
                  frame_err_o <= CHECK_LEAD && sh_lead_nz;
                end else begin
                  bit_cnt <= bit_cnt + 1'b1;
                end
              end
            end
          end
          ST_GAP: begin
            if (gap_done) begin
              state  <= ST_IDLE;
              busy_o <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Cycles the select line has been high, saturating; used by the gap property.
  logic [HW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst)                         hi_cnt <= HW'(GAP_CYC);
    else if (!cs_n_o)                hi_cnt <= '0;
    else if (hi_cnt < HW'(GAP_CYC))  hi_cnt <= hi_cnt + 1'b1;
  end

  assert_clock_idle_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);
  assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  assert_valid_on_cs_rise_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $rose(cs_n_o));
  assert_err_qualified_R6: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> valid_o);
  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> (hi_cnt >= HW'(GAP_CYC)));
  assert_busy_in_frame_R8: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o |-> busy_o);
endmodule

// File: tb/adc_rd_ctrl_bench.sv
module adc_rd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 3;
  localparam int GAP_CYC    = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        abort_i = 1'b0;
  logic        sdi_i = 1'b0;
  logic        cs_n_o, sclk_o, busy_o, valid_o, frame_err_o;
  logic [15:0] data_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_rd_ctrl #(.HALF_DIV(HALF_DIV), .GAP_CYC(GAP_CYC)) u_adc_rd_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i), .sdi_i(sdi_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .busy_o(busy_o), .data_o(data_o),
    .valid_o(valid_o), .frame_err_o(frame_err_o)
  );

  // Converter model and monitors, all evaluated on the falling system-clock edge.
  logic [23:0] word = '0;
  int idx = 0;
  logic pcs = 1'b1, psclk = 1'b0;
  int rise_cnt = 0;
  logic seg_lvl = 1'b0;
  int seg_len = 0;
  int min_hi = 1000, max_hi = 0, min_lo = 1000, max_lo = 0;
  int hi_run = 0;
  int min_gap = 1000;

  always @(negedge clk) begin
    if (pcs && !cs_n_o) idx = 0;
    else if (!cs_n_o && psclk && !sclk_o) idx = idx + 1;
    if (!cs_n_o && !psclk && sclk_o) rise_cnt = rise_cnt + 1;
    if (!cs_n_o) begin
      if (pcs) begin
        seg_lvl = sclk_o; seg_len = 1;
      end else if (sclk_o == seg_lvl) begin
        seg_len = seg_len + 1;
      end else begin
        if (seg_lvl) begin
          if (seg_len < min_hi) min_hi = seg_len;
          if (seg_len > max_hi) max_hi = seg_len;
        end else begin
          if (seg_len < min_lo) min_lo = seg_len;
          if (seg_len > max_lo) max_lo = seg_len;
        end
        seg_lvl = sclk_o; seg_len = 1;
      end
      if (pcs && hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
      hi_run = 0;
    end else begin
      hi_run = hi_run + 1;
    end
    pcs   = cs_n_o;
    psclk = sclk_o;
    sdi_i = (idx < 24) ? word[23 - idx] : 1'b0;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (valid_o) begin got = 1; break; end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n_o == 1 && sclk_o == 0 && busy_o == 0 && valid_o == 0 && frame_err_o == 0,
          "R1", "reset outputs", {cs_n_o, sclk_o, busy_o, valid_o, frame_err_o}, 5'b10000);
  endtask

  task automatic t_frame(input logic [23:0] w);
    bit got;
    int base;
    word = w;
    base = rise_cnt;
    pulse_start();
    wait_valid(got);
    check(got, "R5", "valid strobe seen", got, 1);
    check(data_o == w[15:0], "R4", "result bits", data_o, w[15:0]);
    check(frame_err_o == (w[23:16] != 0), "R6", "framing flag", frame_err_o, w[23:16] != 0);
    check(cs_n_o == 1 && sclk_o == 0, "R5", "select high at strobe", {cs_n_o, sclk_o}, 2'b10);
    check(rise_cnt - base == 24, "R2", "rising edges per frame", rise_cnt - base, 24);
    @(negedge clk);
    check(valid_o == 0, "R5", "strobe lasts one cycle", valid_o, 0);
    repeat (GAP_CYC + 2) @(negedge clk);
  endtask

  task automatic t_widths();
    check(min_hi == HALF_DIV && max_hi == HALF_DIV, "R3", "high phase width", {min_hi, max_hi}, {HALF_DIV, HALF_DIV});
    check(min_lo == HALF_DIV && max_lo == HALF_DIV, "R3", "low phase width", {min_lo, max_lo}, {HALF_DIV, HALF_DIV});
  endtask

  task automatic t_back_to_back();
    bit got;
    word = 24'h00_3C96;
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    wait_valid(got);
    check(got && data_o == 16'h3C96, "R8", "first result", data_o, 16'h3C96);
    @(negedge clk);
    check(busy_o == 1, "R8", "busy held through gap", busy_o, 1);
    word = 24'h00_69E1;
    wait_valid(got);
    check(got && data_o == 16'h69E1, "R8", "pending start served", data_o, 16'h69E1);
    check(min_gap >= GAP_CYC, "R7", "select-high gap", min_gap, GAP_CYC);
    repeat (GAP_CYC + 2) @(negedge clk);
    check(busy_o == 0, "R8", "busy released", busy_o, 0);
  endtask

  task automatic t_abort_drops_pending();
    int bad = 0;
    word = 24'h00_1234;
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    repeat (20) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk) abort_i = 1'b0;
    check(cs_n_o == 1 && sclk_o == 0, "R9", "abort releases select", {cs_n_o, sclk_o}, 2'b10);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (valid_o || !cs_n_o) bad++;
    end
    check(bad == 0, "R9", "no result or restart after abort", bad, 0);
    check(busy_o == 0, "R9", "idle after abort", busy_o, 0);
  endtask

  task automatic t_abort_restart();
    bit got;
    word = 24'h00_BEEF;
    pulse_start();
    repeat (40) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk) begin abort_i = 1'b0; start_i = 1'b1; end
    @(negedge clk) start_i = 1'b0;
    wait_valid(got);
    check(got && data_o == 16'hBEEF, "R9", "restart after abort", data_o, 16'hBEEF);
    check(min_gap >= GAP_CYC, "R7", "gap after abort", min_gap, GAP_CYC);
    repeat (GAP_CYC + 2) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_frame(24'h00_A5C3);
    t_frame(24'h00_0000);
    t_frame(24'h00_FFFF);
    t_frame(24'h00_8001);
    t_frame(24'h40_5AA5);
    t_frame(24'h01_0001);
    t_widths();
    t_back_to_back();
    t_abort_drops_pending();
    t_abort_restart();
    t_widths();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule